// File: doc/BRIEF.md
# Interleaved ADC Sampling-Skew Estimator

This block watches the multiplexed output of a four-way time-interleaved converter and estimates, in the background, how far the sampling instants of three of its channels sit from their ideal positions. Each input cycle may carry one sample together with the index of the channel that produced it. Channel index 0 is the timing reference. The other three channels each get a signed estimate of their skew, expressed as a fraction of one sample period. A downstream fractional-delay corrector can use these estimates directly.

A frame is a valid reference sample, then valid samples from channel indices 1, 2 and 3 in that order. The frame closes when the next valid reference sample arrives. On that cycle three error terms are formed from absolute sample differences, and each term is added to its own saturating accumulator. The loop step is a power of two, so the datapath needs only subtractors, magnitude units, registers and adders, and no multiplier. The middle channel (index 2) is measured against the reference on both sides of it. The two odd channels are measured against their neighbours, and channel index 2 serves as their local reference. All three loops update on the same cycle.

Top module: `tiadc_skew_est`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) sets all three estimates to 0 on the next cycle. It also discards any partly gathered frame.
- R2: Channel codes are 0 for the reference and 1, 2, 3 for the three measured channels. An update happens only on a cycle that carries a valid code-0 sample, and only if valid samples with codes 0, 1, 2 and 3 arrived in that order since the last reset or discard. That code-0 sample also opens the next frame.
- R3: A cycle with sampleValid low changes nothing: no sample is stored, the frame position does not move, and the estimates keep their values, whatever sampleChan and sampleData carry.
- R4: A valid sample whose code breaks the 0,1,2,3 order discards the frame being gathered, and the next close produces no update. Only a later code-0 sample starts a new frame.
- R5: Samples are 8-bit two's complement. With r, a, b, c the frame's samples of codes 0..3 and n the closing code-0 sample, skew2 accumulates |b - a| - |a - r|.
- R6: skew3 accumulates |n - b| - |b - r|.
- R7: skew4 accumulates |n - c| - |c - b|.
- R8: The step is 2^-STEP_SHIFT per sample LSB, where a sample LSB is 2^-(SAMPLE_W-1). Each term is added as an integer to an accumulator whose LSB weighs 2^-(STEP_SHIFT+SAMPLE_W-1) sample periods. Each output is that accumulator arithmetically shifted right to a signed Q1.15 value, which is a floor. By default the shift is 11.
- R9: Each accumulator saturates, so that no output goes beyond 32767 or below -32768 and none wraps round.
- R10: All three estimates change only on the edge that ends an update cycle, and all three update on that same edge. Between updates they hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sampleValid | input | 1 | This cycle carries a sample |
| sampleChan | input | 2 | Channel code of the sample (0 = reference) |
| sampleData | input | SAMPLE_W (8) | Two's complement sample |
| skew2 | output | FRAC_W+1 (16) | Q1.15 skew estimate, channel code 1 |
| skew3 | output | FRAC_W+1 (16) | Q1.15 skew estimate, channel code 2 |
| skew4 | output | FRAC_W+1 (16) | Q1.15 skew estimate, channel code 3 |

## Verification
The stimulus patterns are a constant stream, a pseudo-random stream and a random stream broken by idle cycles that carry junk. A constant stream gives zero terms. Against it, the random streams show whether each channel uses the right pair of neighbours and whether the idle cycles leak into the frame. Streams with broken channel order then show that an incomplete frame never updates. Extreme-value frames are repeated on a second instance with a short step until both rails are reached, which separates saturation from wrap-around. The default instance runs alongside it to confirm the floor shift to Q1.15 at the full-length step.

// File: rtl/skew_est_pkg.sv
package skew_est_pkg;
  localparam int NUM_CHAN = 4;
  localparam int CHAN_W = 2;

  // Strobes from the frame control to the datapath
  typedef struct packed {
    logic [NUM_CHAN-1:0] capture;  // one-hot: store sampleData in slot
    logic                update;   // close frame, add terms
  } skew_strobe_t;

  typedef enum logic [2:0] {
    FR_IDLE,
    FR_HAVE1,
    FR_HAVE2,
    FR_HAVE3,
    FR_HAVE4
  } frame_state_t;
endpackage

// File: rtl/skew_frame_ctrl.sv
module skew_frame_ctrl
  import skew_est_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sampleValid,
  input  logic [CHAN_W-1:0] sampleChan,
  output skew_strobe_t      strobe
);
  frame_state_t state, nextState;

  always_comb begin
    strobe = '0;
    nextState = state;
    if (sampleValid) begin
      if (sampleChan == CHAN_W'(0)) begin
        strobe.capture[0] = 1'b1;
        strobe.update = (state == FR_HAVE4);
        nextState = FR_HAVE1;
      end else if (state == FR_HAVE1 && sampleChan == CHAN_W'(1)) begin
        strobe.capture[1] = 1'b1;
        nextState = FR_HAVE2;
      end else if (state == FR_HAVE2 && sampleChan == CHAN_W'(2)) begin
        strobe.capture[2] = 1'b1;
        nextState = FR_HAVE3;
      end else if (state == FR_HAVE3 && sampleChan == CHAN_W'(3)) begin
        strobe.capture[3] = 1'b1;
        nextState = FR_HAVE4;
      end else begin
        nextState = FR_IDLE;  // order broken: drop the frame
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= FR_IDLE;
    else     state <= nextState;
  end
endmodule

// File: rtl/skew_acc.sv
module skew_acc #(
  parameter int TERM_W = 10,
  parameter int TOP    = 26,
  parameter int FRAC_W = 15
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     update,
  input  logic signed [TERM_W-1:0] term,
  output logic        [FRAC_W:0]   est
);
  localparam int ACC_W = TOP + 1;
  localparam int SUM_W = ACC_W + 1;
  localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {TOP{1'b1}}};
  localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {TOP{1'b0}}};
  localparam logic signed [SUM_W-1:0] SUM_MAX = {2'b00, {TOP{1'b1}}};
  localparam logic signed [SUM_W-1:0] SUM_MIN = {2'b11, {TOP{1'b0}}};

  logic signed [ACC_W-1:0] acc, accNext;
  logic signed [SUM_W-1:0] sum;

  always_comb begin
    sum = {acc[ACC_W-1], acc} + {{(SUM_W-TERM_W){term[TERM_W-1]}}, term};
    if (sum > SUM_MAX)      accNext = ACC_MAX;
    else if (sum < SUM_MIN) accNext = ACC_MIN;
    else                    accNext = sum[ACC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)         acc <= '0;
    else if (update) acc <= accNext;
  end

  // top FRAC_W+1 bits: floor of the accumulator in Q1.15 units
  assign est = acc[ACC_W-1 -: FRAC_W+1];
endmodule

// File: rtl/skew_datapath.sv
module skew_datapath
  import skew_est_pkg::*;
#(
  parameter int SAMPLE_W   = 8,
  parameter int STEP_SHIFT = 19,
  parameter int FRAC_W     = 15
) (
  input  logic                        clk,
  input  logic                        rst,
  input  skew_strobe_t                strobe,
  input  logic [SAMPLE_W-1:0]         sampleData,
  output logic [NUM_CHAN-2:0][FRAC_W:0] est
);
  localparam int TOP    = STEP_SHIFT + SAMPLE_W - 1;
  localparam int TERM_W = SAMPLE_W + 2;

  logic signed [SAMPLE_W-1:0] slot [NUM_CHAN];
  logic signed [TERM_W-1:0]   term [NUM_CHAN-1];
  logic signed [SAMPLE_W-1:0] nextRef;

  function automatic logic [SAMPLE_W:0] absDiff(input logic signed [SAMPLE_W-1:0] a,
                                                input logic signed [SAMPLE_W-1:0] b);
    logic [SAMPLE_W:0] d;
    d = {a[SAMPLE_W-1], a} - {b[SAMPLE_W-1], b};
    return d[SAMPLE_W] ? (~d + 1'b1) : d;
  endfunction

  function automatic logic signed [TERM_W-1:0] magDelta(input logic [SAMPLE_W:0] p,
                                                        input logic [SAMPLE_W:0] q);
    return {1'b0, p} - {1'b0, q};
  endfunction

  genvar g;
  generate
    for (g = 0; g < NUM_CHAN; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (rst)                    slot[g] <= '0;
        else if (strobe.capture[g]) slot[g] <= sampleData;
      end
    end
  endgenerate

  assign nextRef = sampleData;

  // middle channel against reference, odd channels against neighbours
  always_comb begin
    term[0] = magDelta(absDiff(slot[2], slot[1]), absDiff(slot[1], slot[0]));
    term[1] = magDelta(absDiff(nextRef, slot[2]), absDiff(slot[2], slot[0]));
    term[2] = magDelta(absDiff(nextRef, slot[3]), absDiff(slot[3], slot[2]));
  end

  generate
    for (g = 0; g < NUM_CHAN - 1; g++) begin : g_loop
      skew_acc #(
        .TERM_W(TERM_W),
        .TOP   (TOP),
        .FRAC_W(FRAC_W)
      ) u_acc (
        .clk   (clk),
        .rst   (rst),
        .update(strobe.update),
        .term  (term[g]),
        .est   (est[g])
      );
    end
  endgenerate
endmodule

// File: rtl/tiadc_skew_est.sv
module tiadc_skew_est
  import skew_est_pkg::*;
#(
  parameter int SAMPLE_W   = 8,
  parameter int STEP_SHIFT = 19,
  parameter int FRAC_W     = 15
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sampleValid,
  input  logic [1:0]          sampleChan,
  input  logic [SAMPLE_W-1:0] sampleData,
  output logic [FRAC_W:0]     skew2,
  output logic [FRAC_W:0]     skew3,
  output logic [FRAC_W:0]     skew4
);
  skew_strobe_t strobe;
  logic [NUM_CHAN-2:0][FRAC_W:0] est;

  skew_frame_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .sampleValid(sampleValid),
    .sampleChan (sampleChan),
    .strobe     (strobe)
  );

  skew_datapath #(
    .SAMPLE_W  (SAMPLE_W),
    .STEP_SHIFT(STEP_SHIFT),
    .FRAC_W    (FRAC_W)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .sampleData(sampleData),
    .est       (est)
  );

  assign skew2 = est[0];
  assign skew3 = est[1];
  assign skew4 = est[2];
endmodule

// File: rtl/skew_est_checker.sv
module skew_est_checker #(
  parameter int SAMPLE_W   = 8,
  parameter int STEP_SHIFT = 19,
  parameter int FRAC_W     = 15
) (
  input logic            clk,
  input logic            rst,
  input logic            sampleValid,
  input logic [1:0]      sampleChan,
  input logic            update,
  input logic [FRAC_W:0] skew2,
  input logic [FRAC_W:0] skew3,
  input logic [FRAC_W:0] skew4
);
  localparam int OUT_LSB  = STEP_SHIFT + SAMPLE_W - 1 - FRAC_W;
  localparam int MAX_STEP = (((1 << SAMPLE_W) - 1) >> OUT_LSB) + 1;

  function automatic int delta(input logic [FRAC_W:0] now, input logic [FRAC_W:0] was);
    int d;
    d = int'($signed(now)) - int'($signed(was));
    return (d < 0) ? -d : d;
  endfunction

  a_r1_reset_zero: assert property (@(posedge clk)
    rst |=> (skew2 == '0 && skew3 == '0 && skew4 == '0));

  a_r10_hold_between: assert property (@(posedge clk) disable iff (rst)
    !update |=> ($stable(skew2) && $stable(skew3) && $stable(skew4)));

  a_r3_idle_no_update: assert property (@(posedge clk) disable iff (rst)
    !sampleValid |-> !update);

  a_r2_update_on_ref: assert property (@(posedge clk) disable iff (rst)
    update |-> (sampleValid && sampleChan == 2'd0));

  // R8: one update moves each output by at most one term after the floor shift
  a_r8_step_skew2: assert property (@(posedge clk) disable iff (rst)
    update |=> delta(skew2, $past(skew2)) <= MAX_STEP);
  a_r8_step_skew3: assert property (@(posedge clk) disable iff (rst)
    update |=> delta(skew3, $past(skew3)) <= MAX_STEP);
  a_r8_step_skew4: assert property (@(posedge clk) disable iff (rst)
    update |=> delta(skew4, $past(skew4)) <= MAX_STEP);
endmodule

bind tiadc_skew_est skew_est_checker #(
  .SAMPLE_W  (SAMPLE_W),
  .STEP_SHIFT(STEP_SHIFT),
  .FRAC_W    (FRAC_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .sampleValid(sampleValid),
  .sampleChan (sampleChan),
  .update     (strobe.update),
  .skew2      (skew2),
  .skew3      (skew3),
  .skew4      (skew4)
);

// File: tb/test_tiadc_skew_est.sv
`timescale 1ns/1ps
module test_tiadc_skew_est;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sampleValid = 1'b0;
  logic [1:0] sampleChan = 2'd0;
  logic [7:0] sampleData = 8'd0;
  logic [15:0] s2d, s3d, s4d, s2f, s3f, s4f;

  int checks = 0;
  int errors = 0;
  longint accD [3];
  longint accF [3];
  int mState = 0;
  int m [4];
  logic [15:0] lfsr = 16'hACE1;

  localparam int TOP_D = 26, SH_D = 11;  // default STEP_SHIFT 19
  localparam int TOP_F = 15, SH_F = 0;   // fast instance STEP_SHIFT 8

  always #2 clk = ~clk;

  tiadc_skew_est i_tiadc_skew_est (
    .clk(clk), .rst(rst), .sampleValid(sampleValid), .sampleChan(sampleChan),
    .sampleData(sampleData), .skew2(s2d), .skew3(s3d), .skew4(s4d));

  tiadc_skew_est #(.STEP_SHIFT(8)) i_tiadc_skew_est_fast (
    .clk(clk), .rst(rst), .sampleValid(sampleValid), .sampleChan(sampleChan),
    .sampleData(sampleData), .skew2(s2f), .skew3(s3f), .skew4(s4f));

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic longint satAdd(input longint a, input int t, input int top);
    longint s, hi;
    hi = (longint'(1) << top) - 1;
    s = a + t;
    if (s > hi) s = hi;
    if (s < -hi - 1) s = -hi - 1;
    return s;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < 3; i++) begin accD[i] = 0; accF[i] = 0; end
    mState = 0;
  endtask

  task automatic modelStep(input int ch, input int d);
    int t [3];
    if (ch == 0) begin
      if (mState == 4) begin
        t[0] = iabs(m[2] - m[1]) - iabs(m[1] - m[0]);
        t[1] = iabs(d - m[2]) - iabs(m[2] - m[0]);
        t[2] = iabs(d - m[3]) - iabs(m[3] - m[2]);
        for (int i = 0; i < 3; i++) begin
          accD[i] = satAdd(accD[i], t[i], TOP_D);
          accF[i] = satAdd(accF[i], t[i], TOP_F);
        end
      end
      m[0] = d;
      mState = 1;
    end else if (mState == ch) begin
      m[ch] = d;
      mState = ch + 1;
    end else begin
      mState = 0;
    end
  endtask

  task automatic checkAll(input string phase);
    chk({"R5 skew2 ", phase}, int'($signed(s2d)), int'(accD[0] >>> SH_D));
    chk({"R6 skew3 ", phase}, int'($signed(s3d)), int'(accD[1] >>> SH_D));
    chk({"R7 skew4 ", phase}, int'($signed(s4d)), int'(accD[2] >>> SH_D));
    chk({"R8 fast skew2 ", phase}, int'($signed(s2f)), int'(accF[0] >>> SH_F));
    chk({"R8 fast skew3 ", phase}, int'($signed(s3f)), int'(accF[1] >>> SH_F));
    chk({"R8 fast skew4 ", phase}, int'($signed(s4f)), int'(accF[2] >>> SH_F));
  endtask

  task automatic sendSample(input bit v, input int ch, input int d, input string phase);
    @(negedge clk);
    sampleValid = v;
    sampleChan = 2'(ch);
    sampleData = 8'(d);
    if (v) modelStep(ch, d);
    @(posedge clk);
    #1;
    checkAll(phase);
  endtask

  task automatic sendFrame(input int a, input int b, input int c, input int e, input string phase);
    sendSample(1'b1, 0, a, phase);
    sendSample(1'b1, 1, b, phase);
    sendSample(1'b1, 2, c, phase);
    sendSample(1'b1, 3, e, phase);
  endtask

  function automatic int nextRand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return int'($signed(lfsr[7:0]));
  endfunction

  initial begin
    #(4 * 190000);
    errors++;
    $display("FAIL watchdog R2 actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int k2, k3, k4;
    modelReset();
    repeat (3) @(posedge clk);
    #1;
    checkAll("R1 after reset");
    @(negedge clk);
    rst = 1'b0;

    // constant stream: all terms zero
    for (int f = 0; f < 20; f++) sendFrame(37, 37, 37, 37, "const");

    // pseudo-random stream, R10 hold checked every cycle
    for (int f = 0; f < 300; f++) sendFrame(nextRand(), nextRand(), nextRand(), nextRand(), "R10 random");

    // R3: idle cycles with junk between samples
    for (int f = 0; f < 150; f++) begin
      for (int c = 0; c < 4; c++) begin
        int gaps;
        gaps = lfsr[1:0];
        for (int g = 0; g < gaps; g++) sendSample(1'b0, nextRand() & 3, nextRand(), "R3 idle");
        sendSample(1'b1, c, nextRand(), "R3 gapped");
      end
    end
    sendSample(1'b1, 0, 5, "R3 close");

    // R4: broken orders never update
    k2 = int'($signed(s2d)); k3 = int'($signed(s3d)); k4 = int'($signed(s4d));
    sendSample(1'b1, 0, 100, "R4");
    sendSample(1'b1, 2, -100, "R4");
    sendSample(1'b1, 3, 90, "R4");
    sendSample(1'b1, 0, -90, "R4");
    sendSample(1'b1, 1, 120, "R4");
    sendSample(1'b1, 1, -120, "R4");
    sendSample(1'b1, 2, 60, "R4");
    sendSample(1'b1, 3, -60, "R4");
    sendSample(1'b1, 0, 127, "R4");
    chk("R4 skew2 unchanged", int'($signed(s2d)), k2);
    chk("R4 skew3 unchanged", int'($signed(s3d)), k3);
    chk("R4 skew4 unchanged", int'($signed(s4d)), k4);

    // R9: saturation on the fast instance
    for (int f = 0; f < 200; f++) sendFrame(-128, -128, 127, 127, "R9 up");
    sendSample(1'b1, 0, -128, "R9 up close");
    chk("R9 fast skew2 high rail", int'($signed(s2f)), 32767);
    chk("R9 fast skew4 high rail", int'($signed(s4f)), 32767);
    for (int f = 0; f < 400; f++) sendFrame(-128, 127, 127, -128, "R9 down");
    sendSample(1'b1, 0, -128, "R9 down close");
    chk("R9 fast skew2 low rail", int'($signed(s2f)), -32768);
    chk("R9 fast skew4 low rail", int'($signed(s4f)), -32768);

    // R1: reset mid-run clears estimates and the partial frame
    sendSample(1'b1, 1, 3, "pre-reset");
    sendSample(1'b1, 2, 3, "pre-reset");
    sendSample(1'b1, 3, 3, "pre-reset");
    @(negedge clk);
    rst = 1'b1;
    sampleValid = 1'b0;
    modelReset();
    @(posedge clk);
    #1;
    checkAll("R1 mid reset");
    @(negedge clk);
    rst = 1'b0;
    sendSample(1'b1, 0, 50, "R1 no stale frame");
    chk("R1 skew2 zero after reset", int'($signed(s2f)), 0);
    for (int f = 0; f < 30; f++) sendFrame(nextRand(), nextRand(), nextRand(), nextRand(), "R2 restart");
    sendSample(1'b1, 0, 0, "R2 restart close");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule